// File: doc/BRIEF.md
# MMU Control Register File

This block keeps the software-visible control and status state of an instruction-side MMU and a data-side MMU, together with a small load/store-unit control word that holds the two MMU enable bits. Software reaches it through a single register-access port. A select code picks the register group, address bits [6:3] pick one of sixteen slots inside an MMU group, and a write strobe commits the write data. Reads are combinational.

Each slot has its own write rule. Some slots are read-only to software. Some slots do not exist on the instruction side. The fault status slot is cleared by any write whose bit 0 is low. On the data side, that clearing write also wipes the fault address slot. The translation side loads fault addresses through a dedicated load input. When a write changes the stored enable word, the block raises a one-cycle flush pulse so that the translation caches are invalidated. An access to a select code the block does not implement raises a one-cycle error strobe and reads as zero.

Top module: `mmu_ctl_regfile`

## Requirements
- R1: The slot index is address bits [6:3]. Address bits [2:0] have no effect on which slot is read or written.
- R2: Software writes to slot 0 and slot 4 are ignored in both MMU groups.
- R3: In the instruction group, slots 1, 2, 7 and 8 ignore writes and always read zero. Every other slot that is not read-only stores the written data.
- R4: A write to slot 3 (fault status) with data bit 0 equal to 0 stores zero. With data bit 0 equal to 1 it stores the data unchanged.
- R5: In the data group only, a clearing write to slot 3 also sets slot 4 (fault address) to zero. In the instruction group, slot 4 is left untouched.
- R6: A pulse on `flt_ld[g]` loads `flt_addr` into slot 4 of group g (0 = instruction, 1 = data). If a clearing write happens in the same cycle, the load wins.
- R7: The enable word (select `SEL_LSU`) keeps only bit 0 (instruction MMU enable) and bit 1 (data MMU enable) of the written data. It reads back zero-extended.
- R8: `flush_o` is high for exactly the one cycle after a write that changes the stored enable word. A write that leaves the word unchanged gives no pulse.
- R9: A read or write whose select code is not one of the three implemented codes reads zero, changes no state, and raises `unassigned_o` for one cycle after the access.
- R10: After reset every slot and the enable word read zero, and both `flush_o` and `unassigned_o` are low.
- R11: `rdata` reflects the addressed register in the same cycle, with no clock edge needed.
- R12: Select codes are 8'h21 for the instruction group, 8'h22 for the data group and 8'h30 for the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read access strobe |
| wr_en | input | 1 | Write access strobe |
| sel | input | 8 | Register group select code |
| addr | input | 7 | Access address; bits [6:3] give the slot |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Combinational read data |
| flt_ld | input | 2 | Fault address load, bit 0 for the instruction group, bit 1 for the data group |
| flt_addr | input | 64 | Fault address to load |
| flush_o | output | 1 | One-cycle pulse after the enable word changes |
| unassigned_o | output | 1 | One-cycle pulse after an access to an unimplemented select code |

## Verification
The assertions assume that `rd_en` and `wr_en` are never both high, because the error strobe is defined per access. They also assume that the two groups' fault loads and software writes never aim at the same slot except through the documented slot-4 priority. The random stimulus draws one operation per cycle, either a read or a write, never both. It spreads the select codes over the three implemented codes and random unimplemented ones, and raises fault loads only rarely, so that the clear-versus-load collision of R6 is also reached on purpose in directed steps. Enable-word writes are drawn from a narrow value set, so that both changing and repeating writes occur often.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;
   localparam int IDX_W  = 4;
   localparam int NSLOT  = 1 << IDX_W;
   localparam logic [IDX_W-1:0] FSR_IDX = 4'd3;
   localparam logic [IDX_W-1:0] FAR_IDX = 4'd4;

   typedef enum logic [1:0] {GRP_IMMU, GRP_DMMU, GRP_LSU, GRP_NONE} grp_e;

   // software write permission of one slot
   function automatic logic slot_writable(input logic is_data, input logic [IDX_W-1:0] idx);
      logic ok;
      ok = !(idx == 4'd0 || idx == FAR_IDX);
      if (!is_data && (idx == 4'd1 || idx == 4'd2 || idx == 4'd7 || idx == 4'd8))
         ok = 1'b0;
      return ok;
   endfunction
endpackage

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
   import mmu_ctl_pkg::*;
#(
   parameter int DW      = 64,
   parameter bit IS_DATA = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   input  logic             flt_ld,
   input  logic [DW-1:0]    flt_addr,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] slot_q [NSLOT];
   logic          clr_wr;
   logic          far_clr;

   assign clr_wr = wr_en && (idx == FSR_IDX) && !wdata[0];

   generate
      if (DW < 2) begin : g_bad_dw
         $error("mmu_reg_bank: DW must be at least 2");
      end
      if (IS_DATA) begin : g_data
         assign far_clr = clr_wr;
         // R5
         far_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_wr && !flt_ld |=> slot_q[FAR_IDX] == '0);
      end else begin : g_inst
         assign far_clr = 1'b0;
         // R3
         absent_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && (idx == 4'd1 || idx == 4'd7) |=> $stable(slot_q[1]) && $stable(slot_q[7]));
         // R5
         inst_far_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !flt_ld |=> $stable(slot_q[FAR_IDX]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
      end else begin
         for (int i = 0; i < NSLOT; i++) begin
            if (wr_en && idx == IDX_W'(i) && slot_writable(IS_DATA, IDX_W'(i)))
               slot_q[i] <= (IDX_W'(i) == FSR_IDX && !wdata[0]) ? '0 : wdata;
         end
         if (far_clr) slot_q[FAR_IDX] <= '0;
         if (flt_ld)  slot_q[FAR_IDX] <= flt_addr;
      end
   end

   assign rdata = slot_q[idx];

   // R2
   ro_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && idx == 4'd0 |=> $stable(slot_q[0]));
   // R4
   fsr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> slot_q[FSR_IDX] == '0);
   // R6
   flt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flt_ld |=> slot_q[FAR_IDX] == $past(flt_addr));
endmodule

// File: rtl/mmu_lsu_ctl.sv
module mmu_lsu_ctl #(
   parameter int DW      = 64,
   parameter int IEN_BIT = 0,
   parameter int DEN_BIT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] lsu_q,
   output logic          flush_o
);
   localparam logic [DW-1:0] KEEP = (DW'(1) << IEN_BIT) | (DW'(1) << DEN_BIT);

   logic [DW-1:0] next_val;

   generate
      if (IEN_BIT == DEN_BIT || IEN_BIT >= DW || DEN_BIT >= DW) begin : g_bad_bits
         $error("mmu_lsu_ctl: enable bit positions must differ and fit in DW");
      end
   endgenerate

   assign next_val = wdata & KEEP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lsu_q   <= '0;
         flush_o <= 1'b0;
      end else begin
         flush_o <= wr_en && (next_val != lsu_q);
         if (wr_en) lsu_q <= next_val;
      end
   end

   // R8
   flush_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> lsu_q != $past(lsu_q));
   // R8
   idle_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !flush_o && $stable(lsu_q));
   // R7
   lsu_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (lsu_q & ~KEEP) == '0);
endmodule

// File: rtl/mmu_ctl_regfile.sv
module mmu_ctl_regfile
   import mmu_ctl_pkg::*;
#(
   parameter int          DW       = 64,
   parameter int          SEL_W    = 8,
   parameter int          ADDR_W   = 7,
   parameter int          IDX_LSB  = 3,
   parameter int          IEN_BIT  = 0,
   parameter int          DEN_BIT  = 1,
   parameter logic [7:0]  SEL_IMMU = 8'h21,
   parameter logic [7:0]  SEL_DMMU = 8'h22,
   parameter logic [7:0]  SEL_LSU  = 8'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [1:0]        flt_ld,
   input  logic [DW-1:0]     flt_addr,
   output logic              flush_o,
   output logic              unassigned_o
);
   localparam int NGRP = 2;

   grp_e             grp;
   logic [IDX_W-1:0] idx;
   logic [DW-1:0]    bank_rd [NGRP];
   logic [DW-1:0]    lsu_val;
   logic             unk_q;
   logic [IDX_LSB-1:0] unused_addr_lo;

   generate
      if (ADDR_W != IDX_LSB + IDX_W) begin : g_bad_addr
         $error("mmu_ctl_regfile: ADDR_W must equal IDX_LSB + slot index width");
      end
      if (SEL_W != 8) begin : g_bad_sel
         $error("mmu_ctl_regfile: SEL_W must be 8");
      end
   endgenerate

   assign idx            = addr[IDX_LSB +: IDX_W];
   assign unused_addr_lo = addr[IDX_LSB-1:0];

   always_comb begin
      if (sel == SEL_IMMU)      grp = GRP_IMMU;
      else if (sel == SEL_DMMU) grp = GRP_DMMU;
      else if (sel == SEL_LSU)  grp = GRP_LSU;
      else                      grp = GRP_NONE;
   end

   genvar g;
   generate
      for (g = 0; g < NGRP; g++) begin : g_bank
         localparam grp_e MY_GRP = (g == 1) ? GRP_DMMU : GRP_IMMU;
         mmu_reg_bank #(.DW(DW), .IS_DATA(g == 1)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && grp == MY_GRP),
            .idx      (idx),
            .wdata    (wdata),
            .flt_ld   (flt_ld[g]),
            .flt_addr (flt_addr),
            .rdata    (bank_rd[g])
         );
      end
   endgenerate

   mmu_lsu_ctl #(.DW(DW), .IEN_BIT(IEN_BIT), .DEN_BIT(DEN_BIT)) u_lsu (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en && grp == GRP_LSU),
      .wdata   (wdata),
      .lsu_q   (lsu_val),
      .flush_o (flush_o)
   );

   always_comb begin
      unique case (grp)
         GRP_IMMU: rdata = bank_rd[0];
         GRP_DMMU: rdata = bank_rd[1];
         GRP_LSU:  rdata = lsu_val;
         default:  rdata = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) unk_q <= 1'b0;
      else        unk_q <= (rd_en || wr_en) && grp == GRP_NONE;
   end
   assign unassigned_o = unk_q;

   // R9
   unassigned_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unassigned_o |-> $past(rd_en || wr_en) && $past(grp) == GRP_NONE);
   // R9
   unassigned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp == GRP_NONE |-> rdata == '0);
   // R8
   flush_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> $past(wr_en) && $past(sel) == SEL_LSU);
endmodule

// File: tb/mmu_ctl_regfile_bench.sv
module mmu_ctl_regfile_bench;
   localparam logic [7:0] S_I = 8'h21, S_D = 8'h22, S_L = 8'h30;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        rd_en = 0, wr_en = 0;
   logic [7:0]  sel = 0;
   logic [6:0]  addr = 0;
   logic [63:0] wdata = 0, rdata, flt_addr = 0;
   logic [1:0]  flt_ld = 0;
   logic        flush_o, unassigned_o;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [63:0] m_i [16];
   logic [63:0] m_d [16];
   logic [63:0] m_l;

   always #4 clk = ~clk;

   mmu_ctl_regfile u_mmu_ctl_regfile (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .sel(sel),
      .addr(addr), .wdata(wdata), .rdata(rdata), .flt_ld(flt_ld),
      .flt_addr(flt_addr), .flush_o(flush_o), .unassigned_o(unassigned_o));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_read(input logic [7:0] s, input logic [3:0] i);
      if (s == S_I) return m_i[i];
      if (s == S_D) return m_d[i];
      if (s == S_L) return m_l;
      return 64'h0;
   endfunction

   function automatic bit inst_ok(input logic [3:0] i);
      return !(i == 0 || i == 4 || i == 1 || i == 2 || i == 7 || i == 8);
   endfunction

   // one access per cycle; rd label names the requirement of the read check
   task automatic op(input bit r, input bit w, input logic [7:0] s, input logic [6:0] a,
                     input logic [63:0] d, input logic [1:0] fl, input logic [63:0] fa,
                     input string rlab);
      logic [3:0] i;
      bit exp_fl, exp_un;
      i = a[6:3];
      rd_en = r; wr_en = w; sel = s; addr = a; wdata = d; flt_ld = fl; flt_addr = fa;
      #1;
      if (r) check(rlab, rdata, exp_read(s, i));
      exp_un = (r || w) && !(s == S_I || s == S_D || s == S_L);
      exp_fl = w && s == S_L && ((d & 64'h3) != m_l);
      if (w && s == S_I && inst_ok(i)) m_i[i] = (i == 3 && !d[0]) ? 64'h0 : d;
      if (w && s == S_D && i != 0 && i != 4) begin
         m_d[i] = (i == 3 && !d[0]) ? 64'h0 : d;
         if (i == 3 && !d[0]) m_d[4] = 64'h0;
      end
      if (w && s == S_L) m_l = d & 64'h3;
      if (fl[0]) m_i[4] = fa;
      if (fl[1]) m_d[4] = fa;
      @(negedge clk);
      check("R8 flush", {63'b0, flush_o}, {63'b0, exp_fl});
      check("R9 unassigned", {63'b0, unassigned_o}, {63'b0, exp_un});
      rd_en = 0; wr_en = 0; flt_ld = 0;
   endtask

   task automatic rd(input logic [7:0] s, input logic [3:0] i, input string lab);
      op(1, 0, s, {i, 3'b000}, 64'h0, 2'b00, 64'h0, lab);
   endtask
   task automatic wr(input logic [7:0] s, input logic [3:0] i, input logic [63:0] d);
      op(0, 1, s, {i, 3'b000}, d, 2'b00, 64'h0, "");
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 16; k++) begin m_i[k] = 0; m_d[k] = 0; end
      m_l = 0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R10 reset state
      check("R10 flush", {63'b0, flush_o}, 64'h0);
      check("R10 unassigned", {63'b0, unassigned_o}, 64'h0);
      for (int k = 0; k < 16; k++) begin rd(S_I, 4'(k), "R10"); rd(S_D, 4'(k), "R10"); end
      rd(S_L, 0, "R10");
      // R1 low address bits ignored
      op(0, 1, S_D, 7'b0101_111, 64'hA5A5_0000_1234_5678, 0, 0, "");
      op(1, 0, S_D, 7'b0101_010, 0, 0, 0, "R1");
      // R2 read-only slots
      wr(S_D, 0, 64'hFFFF); wr(S_D, 4, 64'hEEEE); wr(S_I, 0, 64'hDDDD); wr(S_I, 4, 64'hCCCC);
      rd(S_D, 0, "R2"); rd(S_D, 4, "R2"); rd(S_I, 0, "R2"); rd(S_I, 4, "R2");
      // R3 absent instruction slots, present ones store
      wr(S_I, 1, 64'h11); wr(S_I, 2, 64'h22); wr(S_I, 7, 64'h77); wr(S_I, 8, 64'h88);
      wr(S_I, 5, 64'h55); wr(S_I, 6, 64'h66);
      rd(S_I, 1, "R3"); rd(S_I, 2, "R3"); rd(S_I, 7, "R3"); rd(S_I, 8, "R3");
      rd(S_I, 5, "R3"); rd(S_I, 6, "R3");
      wr(S_D, 7, 64'h707); rd(S_D, 7, "R3 data slot 7 stores");
      // R4 fault status set and clear
      wr(S_I, 3, 64'hF00D_0001); rd(S_I, 3, "R4");
      wr(S_I, 3, 64'hF00D_0002); rd(S_I, 3, "R4");
      // R5 data clear also wipes fault address, instruction does not
      op(0, 0, S_I, 0, 0, 2'b11, 64'hBEEF_CAFE, "");
      rd(S_D, 4, "R6"); rd(S_I, 4, "R6");
      wr(S_D, 3, 64'h9); wr(S_D, 3, 64'h8);
      rd(S_D, 3, "R5"); rd(S_D, 4, "R5");
      wr(S_I, 3, 64'h0); rd(S_I, 4, "R5");
      // R6 load wins over same-cycle clear
      op(0, 1, S_D, {4'd3, 3'b0}, 64'h0, 2'b10, 64'h1234_ABCD, "");
      rd(S_D, 4, "R6"); rd(S_D, 3, "R6");
      // R7 / R8 enable word
      wr(S_L, 0, 64'hFFFF_FFFF_FFFF_FFFF); rd(S_L, 0, "R7");
      wr(S_L, 5, 64'hFFFF_FFFF_FFFF_FFFC); rd(S_L, 0, "R7");
      wr(S_L, 0, 64'h4); wr(S_L, 0, 64'h2); wr(S_L, 0, 64'h6);
      rd(S_L, 0, "R8");
      // R9 unassigned select
      op(0, 1, 8'h45, {4'd5, 3'b0}, 64'hDEAD, 0, 0, "");
      op(1, 0, 8'h45, {4'd5, 3'b0}, 0, 0, 0, "R9");
      rd(S_D, 5, "R9 no state change");
      // R12 codes distinct groups
      rd(S_I, 5, "R12"); rd(S_D, 5, "R12");
      // random traffic, R11 combinational reads
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] s; logic [63:0] d; logic [1:0] fl; bit w;
         int pick;
         pick = $urandom_range(0, 9);
         s = (pick < 4) ? S_I : (pick < 8) ? S_D : (pick == 8) ? S_L : 8'($urandom_range(0, 255));
         w = $urandom_range(0, 1);
         d = {$urandom, $urandom};
         if (s == S_L) d = 64'($urandom_range(0, 7));
         fl = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         op(!w, w, s, 7'($urandom), d, fl, {$urandom, $urandom}, "R11");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule